// File: doc/BRIEF.md
# Atomic Floating-Point Minimum Memory Unit

This block sits on the memory side of a load/store path. It performs one atomic floating-point minimum-number update at a time. A requester hands over a byte address, a 64-bit operand, a 2-bit size code and a pair of ordering flags. The unit reads the 64-bit memory word that holds the addressed element and finds the IEEE minimum-number of that element and the operand. It then writes the minimum back into the same word, using byte enables. Half, single and double precision elements are supported. The response carries the element exactly as it was before the update, zero-extended to 64 bits.

Before touching memory, the unit screens each request. A disabled feature or an illegal size is reported as undefined. Disabled floating-point access is reported as a trap. A stack-pointer base (index 31) must be 16-byte aligned, and every element must be naturally aligned. A screened-out request gets a response with a nonzero status and causes no memory access. An accepted update keeps the word locked from its read cycle through its write cycle. During both cycles it presents the ordering and tag-check attributes of the access.

Top module: `fp_atomic_min_unit`

## Requirements
- R1: The element width is 8 << req_size. Size codes 1, 2 and 3 select 16, 32 and 64 bits. Size code 0 is answered with rsp_status = 1 (undefined) and causes no memory access.
- R2: When feat_enable is low, the response has rsp_status = 1 and there is no memory access. This takes priority over every other check.
- R3: When fp_enable is low (and the request is not undefined), the response has rsp_status = 2 and there is no memory access.
- R4: An element address that is not a multiple of the element size in bytes gets rsp_status = 3. There is no memory access and memory is unchanged.
- R5: With req_base_idx = 31, an address whose low four bits are not all zero gets rsp_status = 4 and no memory access. This check ranks above R4.
- R6: An accepted update makes exactly two accesses: a read of word req_addr >> 3, then a write of the same word in the very next cycle. mem_lock is high in both cycles.
- R7: rsp_data holds the element as read from memory, zero-extended, with rsp_status = 0. It is not the computed minimum.
- R8: The stored element is the smaller of the memory value and the operand. If exactly one of the two is a quiet NaN (exponent all ones, top fraction bit 1), the other value is stored.
- R9: If either value is a signalling NaN (exponent all ones, fraction nonzero, top fraction bit 0), or both are NaN, the stored element is the positive default quiet NaN and rsp_invalid is 1. The default quiet NaN has exponent all ones and only the top fraction bit set. In every other case rsp_invalid is 0.
- R10: Negative zero counts as smaller than positive zero.
- R11: The element occupies bytes req_addr[2:0] upward within the 64-bit word. Bytes outside the element keep their previous contents.
- R12: While mem_en is high, mem_acquire and mem_release equal the request's acquire and release flags. mem_tagchk is 1 unless req_base_idx is 31.
- R13: req_ready is high only when the unit is idle. busy stays high from acceptance until the response is taken. rsp_valid, rsp_data and rsp_status hold steady while rsp_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_addr | input | ADDR_W | Byte address of the element |
| req_operand | input | 64 | Operand, element in the low bits |
| req_size | input | 2 | Element size code |
| req_acquire | input | 1 | Acquire ordering flag |
| req_release | input | 1 | Release ordering flag |
| req_base_idx | input | 5 | Base register index; 31 means stack pointer |
| feat_enable | input | 1 | Feature enable |
| fp_enable | input | 1 | Floating-point access enable |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 64 | Original element, zero-extended |
| rsp_status | output | 3 | 0 ok, 1 undefined, 2 fp trap, 3 misaligned, 4 stack misaligned |
| rsp_invalid | output | 1 | Invalid-operation flag of the minimum |
| busy | output | 1 | Operation in flight |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W-3 | Word address |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Byte enables for the write |
| mem_rdata | input | 64 | Read data, one cycle after a read |
| mem_lock | output | 1 | Word locked for the read-modify-write |
| mem_acquire | output | 1 | Acquire attribute of the access |
| mem_release | output | 1 | Release attribute of the access |
| mem_tagchk | output | 1 | Access is tag-checked |

## Verification
The embedded properties check the access pattern on every cycle. Each write must come straight after a read of the same word, and every read must be followed at once by its write. No access may start for a request whose screening failed. A response must stay frozen while it is not taken. The minimum datapath is checked continuously to produce only one of its inputs or the default NaN. The stimulus scenarios are what show the numeric choice itself. That covers signed zeros, infinities, subnormals and the NaN classes at each width, the lane placement and the neighbouring bytes kept intact, the zero-extended original value, the screening priority, and the ordering attributes seen at the memory port.

// File: rtl/fpam_pkg.sv
// Package: shared types and format constants for the atomic FP minimum unit.
// Assumes a 64-bit memory word and three IEEE binary formats (16/32/64).
package fpam_pkg;

    localparam int WORD_W      = 64;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int OFF_W       = $clog2(WORD_BYTES);
    localparam int NUM_FMT     = 3;
    localparam int SP_INDEX    = 31;
    localparam int SP_ALIGN_LO = 4;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_UNDEF   = 3'd1,
        ST_FPTRAP  = 3'd2,
        ST_ALIGN   = 3'd3,
        ST_SPALIGN = 3'd4
    } fpam_status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_RESP
    } fpam_state_e;

    // Exponent width of format index f (0 half, 1 single, 2 double).
    function automatic int fmt_exp_w(int f);
        case (f)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    // Fraction width of format index f.
    function automatic int fmt_man_w(int f);
        case (f)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

endpackage

// File: rtl/fpam_minnum.sv
// Module: IEEE minimum-number of two operands of one binary format.
// Purely combinational. A quiet NaN on one side yields the other value;
// a signalling NaN or two NaNs yield the default quiet NaN with invalid.
// Assumes EXP_W >= 2 and MAN_W >= 2.
module fpam_minnum #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] val_a,
    input  logic [EXP_W+MAN_W:0] val_b,
    output logic [EXP_W+MAN_W:0] val_min,
    output logic                 invalid
);
    localparam int TOP = EXP_W + MAN_W;
    localparam logic [TOP:0] DEF_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic a_nan, b_nan, a_snan, b_snan, a_less;

    // Classify both operands as NaN / signalling NaN.
    always_comb begin
        a_nan  = (&val_a[MAN_W +: EXP_W]) && (|val_a[MAN_W-1:0]);
        b_nan  = (&val_b[MAN_W +: EXP_W]) && (|val_b[MAN_W-1:0]);
        a_snan = a_nan && !val_a[MAN_W-1];
        b_snan = b_nan && !val_b[MAN_W-1];
    end

    // Ordered comparison of sign-magnitude values; -0 ranks below +0.
    always_comb begin
        if (val_a[TOP] != val_b[TOP])
            a_less = val_a[TOP];
        else if (!val_a[TOP])
            a_less = val_a[TOP-1:0] < val_b[TOP-1:0];
        else
            a_less = val_a[TOP-1:0] > val_b[TOP-1:0];
    end

    // Pick the result according to the minimum-number NaN rules.
    always_comb begin
        invalid = 1'b0;
        if (a_snan || b_snan || (a_nan && b_nan)) begin
            val_min = DEF_QNAN;
            invalid = 1'b1;
        end else if (a_nan) begin
            val_min = val_b;
        end else if (b_nan) begin
            val_min = val_a;
        end else begin
            val_min = a_less ? val_a : val_b;
        end
    end

    // R8 R9: the result is always one of the inputs or the default NaN.
    always_comb begin
        a_r9_result_source: assert (val_min == val_a || val_min == val_b || val_min == DEF_QNAN);
    end

endmodule

// File: rtl/fpam_lane.sv
// Module: lane steering between a 64-bit memory word and one element.
// Extracts the element at a byte offset (zero-extended) and places a new
// element back at that offset with matching byte enables.
// Assumes the offset is naturally aligned for the size when the output is used.
module fpam_lane
    import fpam_pkg::*;
(
    input  logic [1:0]          size_code,
    input  logic [OFF_W-1:0]    byte_off,
    input  logic [WORD_W-1:0]   rd_word,
    input  logic [WORD_W-1:0]   new_elem,
    output logic [WORD_W-1:0]   cur_elem,
    output logic [WORD_W-1:0]   wr_word,
    output logic [WORD_BYTES-1:0] wr_be
);
    logic [WORD_W-1:0]     elem_mask;
    logic [WORD_BYTES-1:0] be_base;
    logic [OFF_W+2:0]      bit_shift;

    // Element mask and base byte enables for the size code.
    always_comb begin
        case (size_code)
            2'd1:    begin elem_mask = {{(WORD_W-16){1'b0}}, 16'hFFFF}; be_base = WORD_BYTES'(8'h03); end
            2'd2:    begin elem_mask = {{(WORD_W-32){1'b0}}, 32'hFFFF_FFFF}; be_base = WORD_BYTES'(8'h0F); end
            2'd3:    begin elem_mask = '1; be_base = '1; end
            default: begin elem_mask = '0; be_base = '0; end
        endcase
    end

    // Shift the element out of, and back into, its byte lane.
    always_comb begin
        bit_shift = {byte_off, 3'b000};
        cur_elem  = (rd_word >> bit_shift) & elem_mask;
        wr_word   = (new_elem & elem_mask) << bit_shift;
        wr_be     = be_base << byte_off;
    end

endmodule

// File: rtl/fpam_screen.sv
// Module: request screening before any memory access.
// Priority: undefined (feature off or size 0), fp trap, stack-pointer
// alignment, natural alignment. Also derives the tag-check attribute.
module fpam_screen
    import fpam_pkg::*;
(
    input  logic         feat_en,
    input  logic         fp_en,
    input  logic [1:0]   size_code,
    input  logic [3:0]   addr_lo,
    input  logic [4:0]   base_idx,
    output fpam_status_e status,
    output logic         tag_chk
);
    logic misaligned;

    // Natural alignment test for the element size.
    always_comb begin
        case (size_code)
            2'd1:    misaligned = addr_lo[0];
            2'd2:    misaligned = |addr_lo[1:0];
            2'd3:    misaligned = |addr_lo[2:0];
            default: misaligned = 1'b0;
        endcase
    end

    // Ordered fault selection.
    always_comb begin
        tag_chk = (base_idx != 5'(SP_INDEX));
        if (!feat_en || size_code == 2'd0)
            status = ST_UNDEF;
        else if (!fp_en)
            status = ST_FPTRAP;
        else if (!tag_chk && (|addr_lo[SP_ALIGN_LO-1:0]))
            status = ST_SPALIGN;
        else if (misaligned)
            status = ST_ALIGN;
        else
            status = ST_OK;
    end

endmodule

// File: rtl/fp_atomic_min_unit.sv
// Module: atomic floating-point minimum read-modify-write engine (top).
// One operation at a time: accept, screen, read word, compute minimum and
// write back in the next cycle, then hold the response until taken.
// Assumes a synchronous memory returning read data one cycle after mem_en.
module fp_atomic_min_unit
    import fpam_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [63:0]           req_operand,
    input  logic [1:0]            req_size,
    input  logic                  req_acquire,
    input  logic                  req_release,
    input  logic [4:0]            req_base_idx,
    input  logic                  feat_enable,
    input  logic                  fp_enable,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic [63:0]           rsp_data,
    output logic [2:0]            rsp_status,
    output logic                  rsp_invalid,
    output logic                  busy,
    output logic                  mem_en,
    output logic                  mem_we,
    output logic [ADDR_W-4:0]     mem_addr,
    output logic [63:0]           mem_wdata,
    output logic [7:0]            mem_be,
    input  logic [63:0]           mem_rdata,
    output logic                  mem_lock,
    output logic                  mem_acquire,
    output logic                  mem_release,
    output logic                  mem_tagchk
);
    fpam_state_e          state;
    fpam_status_e         scr_status, q_status;
    logic                 scr_tag;
    logic [ADDR_W-1:0]    q_addr;
    logic [WORD_W-1:0]    q_op;
    logic [1:0]           q_size;
    logic                 q_acq, q_rel, q_tag;
    logic [WORD_W-1:0]    q_rsp;
    logic                 q_inv;

    logic [WORD_W-1:0]    cur_elem, wr_word, min_elem;
    logic [WORD_BYTES-1:0] wr_be;
    logic [WORD_W-1:0]    res_all [NUM_FMT];
    logic [NUM_FMT-1:0]   inv_all;
    logic                 min_inv;

    fpam_screen u_screen (
        .feat_en   (feat_enable),
        .fp_en     (fp_enable),
        .size_code (req_size),
        .addr_lo   (req_addr[3:0]),
        .base_idx  (req_base_idx),
        .status    (scr_status),
        .tag_chk   (scr_tag)
    );

    fpam_lane u_lane (
        .size_code (q_size),
        .byte_off  (q_addr[OFF_W-1:0]),
        .rd_word   (mem_rdata),
        .new_elem  (min_elem),
        .cur_elem  (cur_elem),
        .wr_word   (wr_word),
        .wr_be     (wr_be)
    );

    // One minimum datapath per supported format.
    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int EW = fmt_exp_w(g);
        localparam int MW = fmt_man_w(g);
        localparam int W  = 1 + EW + MW;
        logic [W-1:0]      r_fmt;
        logic              i_fmt;
        logic [WORD_W-1:0] ext;

        fpam_minnum #(.EXP_W(EW), .MAN_W(MW)) u_min (
            .val_a   (cur_elem[W-1:0]),
            .val_b   (q_op[W-1:0]),
            .val_min (r_fmt),
            .invalid (i_fmt)
        );

        // Zero-extend this format's result to the word width.
        always_comb begin
            ext        = '0;
            ext[W-1:0] = r_fmt;
        end

        assign res_all[g] = ext;
        assign inv_all[g] = i_fmt;
    end

    // Select the result of the format named by the latched size code.
    always_comb begin
        case (q_size)
            2'd1:    begin min_elem = res_all[0]; min_inv = inv_all[0]; end
            2'd2:    begin min_elem = res_all[1]; min_inv = inv_all[1]; end
            default: begin min_elem = res_all[2]; min_inv = inv_all[2]; end
        endcase
    end

    // Sequencer and request/response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            q_status <= ST_OK;
            q_addr   <= '0;
            q_op     <= '0;
            q_size   <= '0;
            q_acq    <= 1'b0;
            q_rel    <= 1'b0;
            q_tag    <= 1'b0;
            q_rsp    <= '0;
            q_inv    <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        q_status <= scr_status;
                        q_addr   <= req_addr;
                        q_op     <= req_operand;
                        q_size   <= req_size;
                        q_acq    <= req_acquire;
                        q_rel    <= req_release;
                        q_tag    <= scr_tag;
                        q_rsp    <= '0;
                        q_inv    <= 1'b0;
                        state    <= (scr_status == ST_OK) ? S_READ : S_RESP;
                    end
                end
                S_READ:  state <= S_WRITE;
                S_WRITE: begin
                    q_rsp <= cur_elem;
                    q_inv <= min_inv;
                    state <= S_RESP;
                end
                default: begin
                    if (rsp_ready) state <= S_IDLE;
                end
            endcase
        end
    end

    // Handshake and memory port outputs decoded from the state.
    always_comb begin
        req_ready   = (state == S_IDLE);
        busy        = (state != S_IDLE);
        rsp_valid   = (state == S_RESP);
        rsp_data    = q_rsp;
        rsp_status  = q_status;
        rsp_invalid = q_inv;
        mem_en      = (state == S_READ) || (state == S_WRITE);
        mem_we      = (state == S_WRITE);
        mem_addr    = q_addr[ADDR_W-1:OFF_W];
        mem_wdata   = wr_word;
        mem_be      = mem_we ? wr_be : '0;
        mem_lock    = mem_en;
        mem_acquire = mem_en && q_acq;
        mem_release = mem_en && q_rel;
        mem_tagchk  = mem_en && q_tag;
    end

    // R6: a write always follows a read of the same word in the prior cycle.
    a_r6_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> ($past(mem_en) && !$past(mem_we) && mem_addr == $past(mem_addr)));

    // R6: a read is always followed immediately by its write.
    a_r6_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (mem_en && mem_we));

    // R2 R3 R4 R5: screened-out requests never reach memory.
    a_r4_fault_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (q_status == ST_OK));

    // R13: an untaken response is held steady.
    a_r13_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_status)));

endmodule

// File: tb/sim_fp_atomic_min_unit.sv
module sim_fp_atomic_min_unit;

    localparam int ADDR_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              req_valid = 1'b0, req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0]       req_operand = '0;
    logic [1:0]        req_size = '0;
    logic              req_acquire = 1'b0, req_release = 1'b0;
    logic [4:0]        req_base_idx = '0;
    logic              feat_enable = 1'b1, fp_enable = 1'b1;
    logic              rsp_valid, rsp_ready = 1'b0;
    logic [63:0]       rsp_data;
    logic [2:0]        rsp_status;
    logic              rsp_invalid, busy;
    logic              mem_en, mem_we;
    logic [ADDR_W-4:0] mem_addr;
    logic [63:0]       mem_wdata;
    logic [7:0]        mem_be;
    logic [63:0]       mem_rdata;
    logic              mem_lock, mem_acquire, mem_release, mem_tagchk;

    fp_atomic_min_unit #(.ADDR_W(ADDR_W)) u0 (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_operand, .req_size,
        .req_acquire, .req_release, .req_base_idx, .feat_enable, .fp_enable,
        .rsp_valid, .rsp_ready, .rsp_data, .rsp_status, .rsp_invalid, .busy,
        .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_be, .mem_rdata,
        .mem_lock, .mem_acquire, .mem_release, .mem_tagchk
    );

    // Memory model with a backdoor preload port, and an access monitor.
    logic [63:0] bmem [16];
    logic        pre_en = 1'b0, mon_clear = 1'b0;
    logic [3:0]  pre_idx = '0;
    logic [63:0] pre_data = '0;
    int          acc_cnt;
    logic [ADDR_W-4:0] rd_addr_seen, wr_addr_seen;
    logic        acq_seen, rel_seen, tag_seen, lock_all;

    always @(posedge clk) begin
        if (pre_en) begin
            bmem[pre_idx] <= pre_data;
        end else if (mem_en) begin
            if (mem_we) begin
                for (int k = 0; k < 8; k++)
                    if (mem_be[k]) bmem[mem_addr[3:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
            end
            mem_rdata <= bmem[mem_addr[3:0]];
        end
    end

    always @(posedge clk) begin
        if (mon_clear) begin
            acc_cnt  <= 0;
            lock_all <= 1'b1;
        end else if (mem_en) begin
            acc_cnt <= acc_cnt + 1;
            if (!mem_lock) lock_all <= 1'b0;
            if (!mem_we) begin
                rd_addr_seen <= mem_addr;
                acq_seen     <= mem_acquire;
                rel_seen     <= mem_release;
                tag_seen     <= mem_tagchk;
            end else begin
                wr_addr_seen <= mem_addr;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", what, act, exp);
        end
    endtask

    task automatic preload(input logic [3:0] idx, input logic [63:0] data);
        @(negedge clk);
        pre_en = 1'b1; pre_idx = idx; pre_data = data; mon_clear = 1'b1;
        @(negedge clk);
        pre_en = 1'b0; mon_clear = 1'b0;
    endtask

    logic [63:0] got_data;
    logic [2:0]  got_status;
    logic        got_inv;

    task automatic run_op(input logic [1:0] sz, input logic [ADDR_W-1:0] addr,
                          input logic [63:0] op, input logic [4:0] idx,
                          input logic acq, input logic rel);
        @(negedge clk);
        req_valid = 1'b1; req_size = sz; req_addr = addr; req_operand = op;
        req_base_idx = idx; req_acquire = acq; req_release = rel;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        got_data = rsp_data; got_status = rsp_status; got_inv = rsp_invalid;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  sz;
        logic [11:0] addr;
        logic [63:0] init;
        logic [63:0] op;
        logic [63:0] nword;
        logic [63:0] rsp;
        logic        inv;
    } vec_t;
    localparam int VW = $bits(vec_t);
    localparam int NV = 17;
    localparam logic [VW-1:0] VECS [NV] = '{
        {2'd3, 12'h008, 64'h3FF0000000000000, 64'h4000000000000000, 64'h3FF0000000000000, 64'h3FF0000000000000, 1'b0},
        {2'd3, 12'h008, 64'h4000000000000000, 64'hBFF0000000000000, 64'hBFF0000000000000, 64'h4000000000000000, 1'b0},
        {2'd3, 12'h010, 64'h8000000000000000, 64'h0000000000000000, 64'h8000000000000000, 64'h8000000000000000, 1'b0},
        {2'd3, 12'h010, 64'h0000000000000000, 64'h8000000000000000, 64'h8000000000000000, 64'h0000000000000000, 1'b0},
        {2'd3, 12'h018, 64'h7FF8000000000000, 64'h3FF8000000000000, 64'h3FF8000000000000, 64'h7FF8000000000000, 1'b0},
        {2'd3, 12'h018, 64'h4014000000000000, 64'h7FF0000000000001, 64'h7FF8000000000000, 64'h4014000000000000, 1'b1},
        {2'd3, 12'h020, 64'h7FF8000000000000, 64'hFFF8000000000000, 64'h7FF8000000000000, 64'h7FF8000000000000, 1'b1},
        {2'd3, 12'h020, 64'hFFF0000000000000, 64'h3FF0000000000000, 64'hFFF0000000000000, 64'hFFF0000000000000, 1'b0},
        {2'd2, 12'h014, 64'h4000000011223344, 64'h000000003F800000, 64'h3F80000011223344, 64'h0000000040000000, 1'b0},
        {2'd2, 12'h010, 64'h556677887FC00000, 64'h00000000C0400000, 64'h55667788C0400000, 64'h000000007FC00000, 1'b0},
        {2'd2, 12'h018, 64'hAAAAAAAA00000002, 64'h0000000000000001, 64'hAAAAAAAA00000001, 64'h0000000000000002, 1'b0},
        {2'd2, 12'h01C, 64'h7F80000112345678, 64'h000000003F800000, 64'h7FC0000012345678, 64'h000000007F800001, 1'b1},
        {2'd1, 12'h022, 64'h111122223C004444, 64'h000000000000BC00, 64'h11112222BC004444, 64'h0000000000003C00, 1'b0},
        {2'd1, 12'h026, 64'h7E00AAAABBBBCCCC, 64'h0000000000000001, 64'h0001AAAABBBBCCCC, 64'h0000000000007E00, 1'b0},
        {2'd1, 12'h020, 64'h0000000000007C01, 64'h0000000000003C00, 64'h0000000000007E00, 64'h0000000000007C01, 1'b1},
        {2'd1, 12'h024, 64'h0000000000000000, 64'h0000000000008000, 64'h0000800000000000, 64'h0000000000000000, 1'b0},
        {2'd1, 12'h028, 64'h000000000000BC00, 64'h000000000000FC00, 64'h000000000000FC00, 64'h000000000000BC00, 1'b0}
    };

    task automatic summary;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL R13 watchdog: got hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: idle state after reset.
        check(64'(req_ready), 64'd1, "R13 req_ready after reset");
        check(64'(busy), 64'd0, "R13 busy after reset");
        check(64'(rsp_valid), 64'd0, "R13 rsp_valid after reset");
        check(64'(mem_en), 64'd0, "R6 no access after reset");

        // Table of vectors across all three widths.
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            preload(v.addr[6:3], v.init);
            run_op(v.sz, v.addr, v.op, 5'd2, 1'b0, 1'b0);
            check(64'(got_status), 64'd0, $sformatf("R7 status vec %0d", i));
            check(got_data, v.rsp, $sformatf("R7 original value vec %0d", i));
            check(bmem[v.addr[6:3]], v.nword, $sformatf("R8 R10 R11 stored word vec %0d", i));
            check(64'(got_inv), 64'(v.inv), $sformatf("R9 invalid flag vec %0d", i));
            check(64'(acc_cnt), 64'd2, $sformatf("R6 access count vec %0d", i));
            check(64'(rd_addr_seen), 64'(wr_addr_seen), $sformatf("R6 same word vec %0d", i));
            check(64'(rd_addr_seen), 64'(v.addr[11:3]), $sformatf("R6 word address vec %0d", i));
            check(64'(lock_all), 64'd1, $sformatf("R6 lock held vec %0d", i));
        end

        // R10: negative zero beats positive zero in single precision.
        preload(4'd6, 64'h0000000000000000);
        run_op(2'd2, 12'h030, 64'h0000000080000000, 5'd1, 1'b0, 1'b0);
        check(bmem[6], 64'h0000000080000000, "R10 single -0 stored");

        // R1: size code 0 is undefined with no access.
        preload(4'd1, 64'h0123456789ABCDEF);
        run_op(2'd0, 12'h008, 64'h0, 5'd2, 1'b0, 1'b0);
        check(64'(got_status), 64'd1, "R1 size 0 status");
        check(64'(acc_cnt), 64'd0, "R1 size 0 no access");
        check(bmem[1], 64'h0123456789ABCDEF, "R1 size 0 memory unchanged");

        // R2: feature off beats fp off.
        feat_enable = 1'b0; fp_enable = 1'b0;
        preload(4'd1, 64'h0123456789ABCDEF);
        run_op(2'd3, 12'h008, 64'h0, 5'd2, 1'b0, 1'b0);
        check(64'(got_status), 64'd1, "R2 feature off status");
        check(64'(acc_cnt), 64'd0, "R2 feature off no access");
        feat_enable = 1'b1;

        // R3: fp access disabled traps.
        preload(4'd1, 64'h0123456789ABCDEF);
        run_op(2'd3, 12'h008, 64'h0, 5'd2, 1'b0, 1'b0);
        check(64'(got_status), 64'd2, "R3 fp off status");
        check(64'(acc_cnt), 64'd0, "R3 fp off no access");
        check(got_data, 64'd0, "R3 fp off data");
        fp_enable = 1'b1;

        // R4: misaligned elements fault and leave memory alone.
        preload(4'd1, 64'h0123456789ABCDEF);
        run_op(2'd3, 12'h00C, 64'h0, 5'd2, 1'b0, 1'b0);
        check(64'(got_status), 64'd3, "R4 double misaligned status");
        check(bmem[1], 64'h0123456789ABCDEF, "R4 memory unchanged");
        check(64'(acc_cnt), 64'd0, "R4 no access");
        preload(4'd2, 64'h0);
        run_op(2'd2, 12'h012, 64'h0, 5'd2, 1'b0, 1'b0);
        check(64'(got_status), 64'd3, "R4 single misaligned status");
        run_op(2'd1, 12'h011, 64'h0, 5'd2, 1'b0, 1'b0);
        check(64'(got_status), 64'd3, "R4 half odd address status");

        // R5: stack-pointer base needs 16-byte alignment, ranked above R4.
        preload(4'd1, 64'h0123456789ABCDEF);
        run_op(2'd3, 12'h008, 64'h0, 5'd31, 1'b0, 1'b0);
        check(64'(got_status), 64'd4, "R5 sp misaligned status");
        check(64'(acc_cnt), 64'd0, "R5 no access");
        run_op(2'd3, 12'h00C, 64'h0, 5'd31, 1'b0, 1'b0);
        check(64'(got_status), 64'd4, "R5 sp check beats natural alignment");

        // R12: ordering and tag attributes at the memory port.
        preload(4'd1, 64'h3FF0000000000000);
        run_op(2'd3, 12'h008, 64'h4000000000000000, 5'd3, 1'b1, 1'b0);
        check(64'(acq_seen), 64'd1, "R12 acquire attribute");
        check(64'(rel_seen), 64'd0, "R12 release attribute clear");
        check(64'(tag_seen), 64'd1, "R12 tag-checked for index 3");
        preload(4'd2, 64'h3FF0000000000000);
        run_op(2'd3, 12'h010, 64'h4000000000000000, 5'd31, 1'b0, 1'b1);
        check(64'(got_status), 64'd0, "R12 sp aligned accepted");
        check(64'(acq_seen), 64'd0, "R12 acquire attribute clear");
        check(64'(rel_seen), 64'd1, "R12 release attribute");
        check(64'(tag_seen), 64'd0, "R12 no tag check for sp base");

        // R13: response held while not taken; busy and ready follow.
        preload(4'd1, 64'h4000000000000000);
        @(negedge clk);
        req_valid = 1'b1; req_size = 2'd3; req_addr = 12'h008;
        req_operand = 64'h3FF0000000000000; req_base_idx = 5'd2;
        @(negedge clk);
        req_valid = 1'b0;
        check(64'(busy), 64'd1, "R13 busy after acceptance");
        check(64'(req_ready), 64'd0, "R13 not ready while busy");
        while (!rsp_valid) @(negedge clk);
        repeat (3) @(negedge clk);
        check(64'(rsp_valid), 64'd1, "R13 response held");
        check(rsp_data, 64'h4000000000000000, "R13 held data");
        check(64'(busy), 64'd1, "R13 busy until taken");
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(64'(busy), 64'd0, "R13 idle after take");
        check(64'(req_ready), 64'd1, "R13 ready after take");

        summary();
        $finish;
    end

endmodule